// File: doc/BRIEF.md
# 8-bit ALU with Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. In one combinational pass it computes a result from an accumulator operand and a second operand under a 3-bit operation select. It also computes the next value of six condition flags: sign, zero, half-carry, parity/overflow, add/subtract and carry. A flag register inside the block holds the current flags. Increment and decrement read the stored carry, so they can leave it untouched.

Each operation writes its own set of flags. Add, subtract and compare report carry, half-carry and signed overflow. Compare computes the same difference as subtract, but it lowers the write-back enable so the accumulator keeps its value. Increment and decrement take only the accumulator and keep the stored carry. AND, OR and XOR report even parity and force the remaining flags to fixed values. The instruction decoder raises the flag-write enable for every operation that alters flags. It holds the enable low for load-type moves, which leave the flags as they are.

Top module: `alu8_core`

## Requirements
- R1: The result is A+B (ADD, op 0), A−B (SUB, op 1 and CMP, op 2), A&B (op 3), A|B (op 4), A^B (op 5), A+1 (INC, op 6) and A−1 (DEC, op 7), all modulo 256. Operand B is ignored for INC and DEC.
- R2: In the flag byte, bit 7 (S) equals bit 7 of the result. Bit 6 (Z) is 1 exactly when the result is zero.
- R3: Bit 4 (H) is the carry out of bit 3 for ADD and INC, and the borrow into bit 3 for SUB, CMP and DEC. AND sets H to 1. OR and XOR clear it.
- R4: For ADD, SUB, CMP, INC and DEC, bit 2 (P/V) is 1 when the result overflows as a two's-complement signed value.
- R5: For AND, OR and XOR, bit 2 (P/V) is 1 when the result has an even number of set bits.
- R6: Bit 1 (N) is 1 for SUB, CMP and DEC, and 0 for every other operation.
- R7: Bit 0 (C) is the carry out of bit 7 for ADD and the borrow for SUB and CMP. AND, OR and XOR clear it.
- R8: INC and DEC pass the stored carry bit unchanged to the next flags. This includes wrap-around from 0xFF to 0x00 and from 0x00 to 0xFF.
- R9: The write-back enable is 0 for CMP and 1 for every other operation.
- R10: The flag register loads the next flags on a rising clock edge only while the flag-write enable is 1. Otherwise it holds its value.
- R11: After an active-low reset the flag register reads 0x00.
- R12: Flag bits 5 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation select (encoding in R1) |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| flag_we_i | input | 1 | Flag register write enable |
| res_o | output | 8 | Result |
| res_we_o | output | 1 | Result write-back enable |
| flags_next_o | output | 8 | Next flag byte computed this cycle |
| flags_o | output | 8 | Registered flag byte |

## Verification
The bench builds the block with its defaults: an 8-bit data path with the half-carry boundary between bits 3 and 4. At this width every signed-overflow edge, both nibble boundaries and both wrap-around points of increment and decrement can be reached with directed operands such as 0x7F, 0x80, 0x0F, 0x10, 0xFF and 0x00. The random part mixes all eight operations with a flag-write enable that is low about a quarter of the time. Increment and decrement therefore see both stored carry values, and the register hold path is exercised between loads.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_CMP = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_XOR = 3'd5,
        OP_INC = 3'd6,
        OP_DEC = 3'd7
    } alu_op_e;

    localparam int FLAG_W = 8;
    localparam int BIT_S  = 7;
    localparam int BIT_Z  = 6;
    localparam int BIT_H  = 4;
    localparam int BIT_PV = 2;
    localparam int BIT_N  = 1;
    localparam int BIT_C  = 0;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_CLR = '{s: 1'b0, z: 1'b0, h: 1'b0, pv: 1'b0, n: 1'b0, c: 1'b0};

    function automatic logic [FLAG_W-1:0] pack_flags(input flags_t f);
        logic [FLAG_W-1:0] v;
        v         = '0;
        v[BIT_S]  = f.s;
        v[BIT_Z]  = f.z;
        v[BIT_H]  = f.h;
        v[BIT_PV] = f.pv;
        v[BIT_N]  = f.n;
        v[BIT_C]  = f.c;
        return v;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              half_o,
    output logic              ovf_o
);
    localparam int NIB_W = DATA_W / 2;
    localparam int MSB   = DATA_W - 1;

    logic [DATA_W-1:0] b_x;
    logic [DATA_W:0]   full;
    logic [NIB_W:0]    low;

    always_comb begin
        b_x     = sub_i ? ~b_i : b_i;
        full    = {1'b0, a_i} + {1'b0, b_x} + {{DATA_W{1'b0}}, sub_i};
        low     = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_x[NIB_W-1:0]} + {{NIB_W{1'b0}}, sub_i};
        sum_o   = full[DATA_W-1:0];
        // For subtraction the raw carry is the inverse of the borrow
        carry_o = full[DATA_W] ^ sub_i;
        half_o  = low[NIB_W] ^ sub_i;
        ovf_o   = (a_i[MSB] == b_x[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [1:0]        sel_i,
    output logic [DATA_W-1:0] res_o,
    output logic              even_o
);
    // sel_i: 0 = AND, 1 = OR, 2 = XOR
    logic [DATA_W-1:0] lanes [3];

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign lanes[0][g] = a_i[g] & b_i[g];
        assign lanes[1][g] = a_i[g] | b_i[g];
        assign lanes[2][g] = a_i[g] ^ b_i[g];
    end

    always_comb begin
        unique case (sel_i)
            2'd0:    res_o = lanes[0];
            2'd1:    res_o = lanes[1];
            default: res_o = lanes[2];
        endcase
        even_o = ~^res_o;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              flag_we_i,
    output logic [DATA_W-1:0] res_o,
    output logic              res_we_o,
    output logic [FLAG_W-1:0] flags_next_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        flags_t            fl;
    } calc_t;

    alu_op_e           op;
    logic              is_step, is_sub, is_logic;
    logic [DATA_W-1:0] arith_b;
    logic [DATA_W-1:0] as_sum;
    logic              as_carry, as_half, as_ovf;
    logic [1:0]        lg_sel;
    logic [DATA_W-1:0] lg_res;
    logic              lg_even;

    calc_t  calc_d;
    flags_t flags_d, flags_q;

    always_comb begin
        op       = alu_op_e'(op_i);
        is_step  = (op == OP_INC) || (op == OP_DEC);
        is_sub   = (op == OP_SUB) || (op == OP_CMP) || (op == OP_DEC);
        is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
        arith_b  = is_step ? ONE : b_i;
        unique case (op)
            OP_AND:  lg_sel = 2'd0;
            OP_OR:   lg_sel = 2'd1;
            default: lg_sel = 2'd2;
        endcase
    end

    alu8_addsub #(.DATA_W(DATA_W)) i_addsub (
        .a_i     (a_i),
        .b_i     (arith_b),
        .sub_i   (is_sub),
        .sum_o   (as_sum),
        .carry_o (as_carry),
        .half_o  (as_half),
        .ovf_o   (as_ovf)
    );

    alu8_logic #(.DATA_W(DATA_W)) i_logic (
        .a_i    (a_i),
        .b_i    (b_i),
        .sel_i  (lg_sel),
        .res_o  (lg_res),
        .even_o (lg_even)
    );

    // Process 1: every next value
    always_comb begin
        calc_d     = '0;
        calc_d.res = is_logic ? lg_res : as_sum;
        calc_d.we  = (op != OP_CMP);
        calc_d.fl.s = calc_d.res[MSB];
        calc_d.fl.z = (calc_d.res == '0);
        if (is_logic) begin
            calc_d.fl.h  = (op == OP_AND);
            calc_d.fl.pv = lg_even;
            calc_d.fl.n  = 1'b0;
            calc_d.fl.c  = 1'b0;
        end else begin
            calc_d.fl.h  = as_half;
            calc_d.fl.pv = as_ovf;
            calc_d.fl.n  = is_sub;
            calc_d.fl.c  = is_step ? flags_q.c : as_carry;
        end
        flags_d = flag_we_i ? calc_d.fl : flags_q;
    end

    // Process 2: flag register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= FLAGS_CLR;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign res_o        = calc_d.res;
    assign res_we_o     = calc_d.we;
    assign flags_next_o = pack_flags(calc_d.fl);
    assign flags_o      = pack_flags(flags_q);

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [2:0]        op_i,
    input logic              flag_we_i,
    input logic [DATA_W-1:0] res_o,
    input logic              res_we_o,
    input logic [FLAG_W-1:0] flags_next_o,
    input logic [FLAG_W-1:0] flags_o
);
    logic chk_logic, chk_step, chk_neg;
    assign chk_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR);
    assign chk_step  = (op_i == OP_INC) || (op_i == OP_DEC);
    assign chk_neg   = (op_i == OP_SUB) || (op_i == OP_CMP) || (op_i == OP_DEC);

    p_sign_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_next_o[BIT_S] == res_o[DATA_W-1]) && (flags_next_o[BIT_Z] == (res_o == '0)));

    p_parity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_logic |-> (flags_next_o[BIT_PV] == ~^res_o));

    p_nflag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_neg |-> flags_next_o[BIT_N]);

    p_logic_c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_logic |-> !flags_next_o[BIT_C]);

    p_keep_c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_step |-> (flags_next_o[BIT_C] == flags_o[BIT_C]));

    p_cmp_nowb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_CMP) |-> !res_we_o);

    p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flag_we_i |=> $stable(flags_o));

    p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_we_i |=> (flags_o == $past(flags_next_o)));

endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (op_i),
    .flag_we_i    (flag_we_i),
    .res_o        (res_o),
    .res_we_o     (res_we_o),
    .flags_next_o (flags_next_o),
    .flags_o      (flags_o)
);

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
module test_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op = 3'd0;
    logic [7:0] a = 8'd0, b = 8'd0;
    logic       fwe = 1'b0;
    logic [7:0] res, fnext, fq;
    logic       rwe;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_q = 8'h00;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core i_alu8_core (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
        .flag_we_i(fwe), .res_o(res), .res_we_o(rwe),
        .flags_next_o(fnext), .flags_o(fq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%02h b=%02h got=%02h exp=%02h", req, op, a, b, got, exp);
        end
    endtask

    // Returns {we, result, flags}
    function automatic logic [16:0] model(input logic [2:0] o, input logic [7:0] x,
                                          input logic [7:0] y, input logic c_old);
        int r, sx, sy, sr;
        logic [7:0] rb;
        logic s_, z_, h_, p_, n_, c_, w_;
        sx = (x > 127) ? int'(x) - 256 : int'(x);
        if (o == 3'd6 || o == 3'd7) y = 8'd1;
        sy = (y > 127) ? int'(y) - 256 : int'(y);
        w_ = (o != 3'd2);
        case (o)
            3'd0, 3'd6: begin
                r = int'(x) + int'(y); sr = sx + sy;
                h_ = ((x & 8'h0F) + (y & 8'h0F)) > 15;
                c_ = (o == 3'd6) ? c_old : (r > 255);
                p_ = (sr > 127) || (sr < -128); n_ = 1'b0;
            end
            3'd1, 3'd2, 3'd7: begin
                r = int'(x) - int'(y); sr = sx - sy;
                h_ = (x & 8'h0F) < (y & 8'h0F);
                c_ = (o == 3'd7) ? c_old : (x < y);
                p_ = (sr > 127) || (sr < -128); n_ = 1'b1;
            end
            default: begin
                r = (o == 3'd3) ? int'(x & y) : (o == 3'd4) ? int'(x | y) : int'(x ^ y);
                h_ = (o == 3'd3); c_ = 1'b0; n_ = 1'b0;
                p_ = ($countones(r[7:0]) % 2) == 0;
            end
        endcase
        rb = r[7:0];
        s_ = rb[7]; z_ = (rb == 8'd0);
        return {w_, rb, s_, z_, 1'b0, h_, 1'b0, p_, n_, c_};
    endfunction

    task automatic apply(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y, input logic we);
        logic [16:0] m;
        @(negedge clk);
        check("R10 flag register", fq, exp_q);
        op = o; a = x; b = y; fwe = we;
        #1;
        m = model(o, x, y, exp_q[0]);
        check(((o == 3'd6) || (o == 3'd7)) ? "R1 result INC/DEC" : "R1 result", res, m[15:8]);
        check("R9 write-back", {7'd0, rwe}, {7'd0, m[16]});
        check("R2 S/Z", {6'd0, fnext[7:6]}, {6'd0, m[7:6]});
        check("R3 H", {7'd0, fnext[4]}, {7'd0, m[4]});
        check((o >= 3'd3 && o <= 3'd5) ? "R5 parity" : "R4 overflow", {7'd0, fnext[2]}, {7'd0, m[2]});
        check("R6 N", {7'd0, fnext[1]}, {7'd0, m[1]});
        check((o >= 3'd6) ? "R8 carry kept" : "R7 carry", {7'd0, fnext[0]}, {7'd0, m[0]});
        check("R12 reserved bits", {6'd0, fnext[5], fnext[3]}, 8'd0);
        if (we) exp_q = m[7:0];
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset flags", fq, 8'h00);
        rst_n = 1'b1;
        // directed corners
        apply(3'd0, 8'h7F, 8'h01, 1'b1);  // signed overflow, half carry
        apply(3'd0, 8'hFF, 8'h01, 1'b1);  // carry out, zero
        apply(3'd1, 8'h80, 8'h01, 1'b1);  // overflow on subtract
        apply(3'd1, 8'h10, 8'h01, 1'b1);  // half borrow
        apply(3'd2, 8'h42, 8'h42, 1'b1);  // CMP equal, R9 no write-back
        apply(3'd2, 8'h01, 8'h02, 1'b1);  // CMP borrow
        apply(3'd4, 8'h00, 8'h00, 1'b1);  // OR A,A on zero
        apply(3'd4, 8'h5A, 8'h5A, 1'b1);  // OR A,A keeps value
        apply(3'd5, 8'hC3, 8'hC3, 1'b1);  // XOR A,A -> 0
        apply(3'd3, 8'hF0, 8'h3C, 1'b1);  // AND sets H
        apply(3'd0, 8'hFF, 8'hFF, 1'b1);  // set carry
        apply(3'd6, 8'hFF, 8'h00, 1'b1);  // INC wrap keeps C=1
        apply(3'd6, 8'h7F, 8'h55, 1'b1);  // INC overflow, B ignored
        apply(3'd7, 8'h00, 8'hAA, 1'b1);  // DEC wrap keeps C
        apply(3'd7, 8'h80, 8'h00, 1'b1);  // DEC overflow
        apply(3'd0, 8'h0F, 8'h01, 1'b0);  // flags hold (R10)
        apply(3'd3, 8'h00, 8'h00, 1'b0);
        for (int i = 0; i < 4000; i++) begin
            apply(3'($urandom % 8), 8'($urandom), 8'($urandom), ($urandom % 4) != 0);
        end
        @(negedge clk);
        check("R10 flag register", fq, exp_q);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule